// File: doc/BRIEF.md
# Sponge Message Padding Buffer

This block sits in front of a sponge permutation with a 576-bit rate. A message arrives as a stream of 64-bit words over a valid/ready handshake. The final word carries a flag and a count of its valid bytes. The block collects nine words into one rate block and presents the block to the permutation engine with a valid flag. It holds that block until the engine acknowledges it, then clears its buffer and accepts words again. New words can therefore be collected while the permutation is still running on the previous block.

At the end of the message the block applies multi-rate padding. The domain byte 0x06 is placed directly after the last message byte. The top bit of the final byte of the block is set. Every byte in between is zero. If the message fills a block exactly, that block goes out as plain data and a second block that holds only padding follows it. The block that carries the padding is flagged as the last block of the message.

Top module: `sponge_pad_buffer`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: Byte i of the message within a block, counted from 0, appears at bits 8i+7 to 8i of `out_data`. Byte k of an input word occupies bits 8k+7 to 8k of `in_word`.
- R3: After nine accepted words, none of which is flagged last, the block raises `out_valid` with `out_last` at 0.
- R4: `in_ready` is 0 whenever `out_valid` is 1. A word offered in that time is not consumed and does not change the pending block.
- R5: While `out_valid` is 1 and `out_ack` is 0, `out_data` and `out_last` stay unchanged.
- R6: The buffer is cleared when a block is acknowledged and also by reset. No byte of an earlier block or of an unfinished message reaches a later block. After a last block is acknowledged, `in_ready` is 1 again in the next cycle.
- R7: On the word flagged by `in_last`, `in_nbytes` gives the number of valid low bytes, and the value 0 means all 8. Bytes above that count are discarded.
- R8: The byte after the last message byte gets 0x06 XORed in, bit 575 of the final block is set, and all other padding bytes are 0.
- R9: When the last message byte is byte 70 of a block, byte 71 of that block is 0x86.
- R10: A message whose length is a multiple of 72 bytes produces its data blocks with `out_last` at 0. These are followed by one block whose byte 0 is 0x06, whose byte 71 is 0x80 and whose other bytes are zero.
- R11: `out_last` is 1 only on the block that carries the padding, and that block is the last one produced for the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken this cycle |
| in_word | input | 64 | Message word, little-endian bytes |
| in_last | input | 1 | Word is the final one of the message |
| in_nbytes | input | 3 | Valid bytes in the final word, 0 means 8 |
| out_valid | output | 1 | Rate block ready for the permutation |
| out_data | output | 576 | Rate block, byte i at bits 8i+7 to 8i |
| out_last | output | 1 | Block carries the message padding |
| out_ack | input | 1 | Permutation engine takes the block |

## Verification
The bench covers message lengths that end a byte short of a block, so the domain byte and the closing bit share byte 71. A design that placed them separately would yield 0x06 or 0x80 instead of 0x86. Messages that end exactly on a block boundary check that a padding-only block follows. A design that skipped it would emit an unpadded final block flagged as data, or would pad past the block edge. Final words carry junk above their byte count, which exposes a missing byte mask. Slow acknowledges and a reset in the middle of a message show whether pending data moves while it is held, and whether stale bytes leak into the next block.

// File: rtl/sponge_pad_buffer.sv
module sponge_pad_buffer #(
  parameter int WORD_W = 64,
  parameter int RATE_W = 576
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [WORD_W-1:0]        in_word,
  input  logic                     in_last,
  input  logic [$clog2(WORD_W/8)-1:0] in_nbytes,
  output logic                     out_valid,
  output logic [RATE_W-1:0]        out_data,
  output logic                     out_last,
  input  logic                     out_ack
);
  localparam int WORDS      = RATE_W / WORD_W;
  localparam int WBYTES     = WORD_W / 8;
  localparam int RBYTES     = RATE_W / 8;
  localparam int IDX_W      = $clog2(WORDS);
  localparam int NB_W       = $clog2(WBYTES) + 1;
  localparam int POS_W      = $clog2(RBYTES + 1);
  localparam logic [RATE_W-1:0] TOP_BIT  = {1'b1, {(RATE_W-1){1'b0}}};
  localparam logic [RATE_W-1:0] DOM_BYTE = RATE_W'(8'h06);

  logic [RATE_W-1:0] buf_q;
  logic [IDX_W-1:0]  idx_q;
  logic              valid_q, last_q, pend_q;

  logic [NB_W-1:0]   nb_eff;
  logic [WORD_W-1:0] word_m;
  logic [RATE_W-1:0] placed, dom;
  logic [POS_W-1:0]  pad_pos;
  logic              accept, at_edge, full_now;

  assign nb_eff = (in_nbytes == '0) ? NB_W'(WBYTES) : NB_W'(in_nbytes);

  for (genvar k = 0; k < WBYTES; k++) begin : g_mask
    assign word_m[8*k +: 8] = (!in_last || (NB_W'(k) < nb_eff)) ? in_word[8*k +: 8] : 8'h00;
  end

  assign placed   = RATE_W'(word_m) << (32'(idx_q) * WORD_W);
  assign pad_pos  = POS_W'(idx_q) * POS_W'(WBYTES) + POS_W'(nb_eff);
  assign at_edge  = (pad_pos == POS_W'(RBYTES));
  assign dom      = DOM_BYTE << (32'(pad_pos) * 8);
  assign full_now = (idx_q == IDX_W'(WORDS - 1));
  assign in_ready = !valid_q;
  assign accept   = in_valid && in_ready;

  assign out_valid = valid_q;
  assign out_data  = buf_q;
  assign out_last  = last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else if (valid_q && out_ack) begin
      idx_q <= '0;
      if (pend_q) begin
        buf_q   <= DOM_BYTE | TOP_BIT;
        valid_q <= 1'b1;
        last_q  <= 1'b1;
        pend_q  <= 1'b0;
      end else begin
        buf_q   <= '0;
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end
    end else if (accept) begin
      if (in_last) begin
        idx_q   <= '0;
        valid_q <= 1'b1;
        if (at_edge) begin
          buf_q  <= buf_q | placed;
          last_q <= 1'b0;
          pend_q <= 1'b1;
        end else begin
          buf_q  <= buf_q | placed | dom | TOP_BIT;
          last_q <= 1'b1;
        end
      end else begin
        buf_q <= buf_q | placed;
        if (full_now) begin
          idx_q   <= '0;
          valid_q <= 1'b1;
          last_q  <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

module sponge_pad_buffer_chk #(
  parameter int RATE_W = 576
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic [RATE_W-1:0] out_data,
  input logic              out_last,
  input logic              out_ack
);
  a_r4_no_take_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ack) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r8_top_bit_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> out_data[RATE_W-1]);

  a_r6_ready_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ack && out_last) |=> (!out_valid && in_ready));

  a_r11_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

bind sponge_pad_buffer sponge_pad_buffer_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .out_last(out_last), .out_ack(out_ack)
);

// File: tb/tb_sponge_pad_buffer.sv
module tb_sponge_pad_buffer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_word = '0;
  logic         in_last = 1'b0;
  logic [2:0]   in_nbytes = '0;
  logic         out_valid;
  logic [575:0] out_data;
  logic         out_last;
  logic         out_ack = 1'b0;

  always #10 clk = ~clk;

  sponge_pad_buffer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_last(in_last), .in_nbytes(in_nbytes),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ack(out_ack)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [575:0] act, input logic [575:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // message length, byte seed, acknowledge delay
  localparam int NT = 10;
  localparam int LENS [NT] = '{1, 5, 8, 64, 71, 72, 100, 143, 144, 20};
  localparam int SEEDS[NT] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10};
  localparam int DLYS [NT] = '{0, 1, 0, 2, 0, 3, 0, 1, 0, 5};

  function automatic logic [7:0] mb(int seed, int i);
    return 8'((i * 29 + seed * 7 + 3) ^ (i >> 3));
  endfunction

  function automatic logic [575:0] exp_blk(int len, int seed, int b, int nb);
    logic [575:0] r = '0;
    for (int j = 0; j < 72; j++) begin
      int idx = b * 72 + j;
      logic [7:0] v = (idx < len) ? mb(seed, idx) : 8'h00;
      if (idx == len) v = v ^ 8'h06;
      if (b == nb - 1 && j == 71) v = v | 8'h80;
      r[8*j +: 8] = v;
    end
    return r;
  endfunction

  logic [575:0] got_d [4];
  bit           got_l [4];
  logic [575:0] first_seen;
  int nblk = 0;
  int ack_delay = 0;
  int waitc = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      out_ack = 1'b0;
      waitc = 0;
    end else if (out_ack) begin
      out_ack = 1'b0;
      if (nblk > 0 && nblk <= 4 && got_l[nblk-1])
        chk(in_ready && !out_valid, "R6 ready after final ack", {574'd0, out_valid, in_ready}, 576'd1);
    end else if (out_valid) begin
      if (waitc == 0) begin
        first_seen = out_data;
        chk(!in_ready, "R4 in_ready low with block pending", 576'(in_ready), 576'd0);
      end
      if (waitc >= ack_delay) begin
        chk(out_data == first_seen, "R5 block held until ack", out_data, first_seen);
        if (nblk < 4) begin
          got_d[nblk] = out_data;
          got_l[nblk] = out_last;
        end
        nblk++;
        out_ack = 1'b1;
        waitc = 0;
      end else begin
        waitc++;
      end
    end
  end

  task automatic send_msg(int len, int seed);
    int nw = (len + 7) / 8;
    for (int w = 0; w < nw; w++) begin
      logic [63:0] d;
      for (int k = 0; k < 8; k++) begin
        int idx = w * 8 + k;
        d[8*k +: 8] = (idx < len) ? mb(seed, idx) : 8'hA5;
      end
      in_word   = d;
      in_last   = (w == nw - 1);
      in_nbytes = (w == nw - 1) ? 3'((len - w * 8) % 8) : 3'd0;
      in_valid  = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run_msg(int len, int seed, int dly, string tag);
    int nb = len / 72 + 1;
    nblk = 0;
    ack_delay = dly;
    send_msg(len, seed);
    for (int t = 0; t < 400 && nblk < nb; t++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(nblk == nb, (len % 72 == 0) ? "R10 block count" : "R3 block count", 576'(nblk), 576'(nb));
    for (int b = 0; b < nb && b < 4; b++) begin
      chk(got_d[b] == exp_blk(len, seed, b, nb), {"R2 ", tag, " block content"}, got_d[b], exp_blk(len, seed, b, nb));
      chk(got_l[b] == (b == nb - 1), (b == nb - 1) ? "R11 last flag" : "R3 data block not last",
          576'(got_l[b]), 576'(b == nb - 1));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_last && in_ready, "R1 reset state",
        {573'd0, out_valid, out_last, in_ready}, 576'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int t = 0; t < NT; t++) begin
      string tag;
      if (LENS[t] % 72 == 0)       tag = "R10 boundary";
      else if (LENS[t] % 72 == 71) tag = "R9 shared byte";
      else if (LENS[t] % 8 != 0)   tag = "R7 partial word";
      else                         tag = "R8 padding";
      run_msg(LENS[t], SEEDS[t], DLYS[t], tag);
    end

    // R6: reset in the middle of a message leaves no residue
    in_word = 64'hFFFF_FFFF_FFFF_FFFF;
    in_last = 1'b0;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!out_valid && in_ready, "R1 reset mid message", {574'd0, out_valid, in_ready}, 576'd1);
    rst_n = 1'b1;
    @(negedge clk);
    run_msg(5, 11, 0, "R6 after reset");
    run_msg(72, 12, 2, "R10 boundary again");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule